// File: doc/BRIEF.md
# Bus Controller Instruction Word Guard

This block sits between the instruction fetch path of an autonomous bus controller sequencer and its execution stage. Each fetched 16-bit word is presented with a valid strobe and a flag saying whether the word is an instruction or a block pointer parameter. For an instruction, the guard checks three things: odd parity over all sixteen bits, a legal opcode, and a reserved field that must be zero. For a pointer parameter, it checks that the pointer is aligned to an 8-word boundary.

Any failed check traps the sequencer. A halt output is raised and held until the controller is started again. A one-cycle interrupt pulse is also raised when interrupts are enabled. The guard also keeps the sequencer's call stack pointer. The pointer moves on accepted call and return instructions and is cleared by every start pulse.

Top module: `bcw_word_guard`

## Requirements
- R1: An instruction word (word_valid_i=1, param_i=0) whose sixteen bits hold an even number of ones is a parity error.
- R2: The opcode is bits 15:10. With the default legal mask, opcodes 0 to 15 are legal and any opcode from 16 to 63 is an error.
- R3: Bits 9:5 of an instruction word must be 5'b00000. Any other value is an error.
- R4: An error in an accepted instruction word sets halt_o in the cycle after the word is sampled. halt_o then stays high until a start pulse.
- R5: When irq_en_i=1, an instruction error gives par_irq_o a pulse of exactly one cycle, in the same cycle halt_o rises. When irq_en_i=0, par_irq_o stays low but halt_o is still set.
- R6: A pointer parameter word (param_i=1) whose bits 2:0 are not 000 sets halt_o. When irq_en_i=1 it also gives align_irq_o a one-cycle pulse. Parity, opcode and the reserved field are not checked on parameter words.
- R7: A start pulse (start_i=1) clears halt_o and sp_o in the next cycle. A word presented in the same cycle as start_i is ignored.
- R8: After reset, halt_o=1, sp_o=0, and both interrupt outputs are 0.
- R9: While halt_o=1, fetched words are ignored: they raise no interrupt and leave sp_o unchanged.
- R10: An accepted error-free instruction with opcode 6'h04 (call) increments sp_o, saturating at 8. An accepted error-free instruction with opcode 6'h05 (return) decrements sp_o, stopping at 0. Parameter words never move sp_o.
- R11: An error-free word leaves halt_o low and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Controller start pulse |
| word_valid_i | input | 1 | Fetched word strobe |
| word_i | input | 16 | Fetched word |
| param_i | input | 1 | 1 = word is a block pointer parameter, 0 = instruction |
| irq_en_i | input | 1 | Interrupt enable for both interrupt outputs |
| halt_o | output | 1 | Sequencer halted |
| par_irq_o | output | 1 | Instruction error interrupt pulse |
| align_irq_o | output | 1 | Pointer alignment interrupt pulse |
| sp_o | output | 4 | Call stack pointer |

## Verification
The instruction patterns are chosen so that each one breaks exactly one check: a word with correct parity but an opcode just above the legal range, a word with a reserved bit set at each end of the field, and a word with good fields but one flipped parity bit. A halt on any of these words can therefore be traced to a single rule. The pointer patterns include an aligned word with even parity, which shows that parity is not checked on parameters, and misaligned values in bit 0 and in bit 2. The directed sequences cover the remaining behaviour: trapping with interrupts enabled and disabled, a start pulse arriving together with a bad word, words sent while halted, and pushing and popping the stack past both of its limits.

// File: rtl/bcw_pkg.sv
package bcw_pkg;

    localparam int WORD_W    = 16;
    localparam int OPC_LSB   = 10;
    localparam int OPC_W     = WORD_W - OPC_LSB;
    localparam int OPC_N     = 1 << OPC_W;
    localparam int RSV_LSB   = 5;
    localparam int RSV_W     = 5;
    localparam int ALIGN_W   = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OPC_W-1:0]  opc_t;

    typedef struct packed {
        logic parity_bad;
        logic opc_bad;
        logic rsv_bad;
    } instr_err_t;

    typedef enum logic [1:0] {
        SP_HOLD = 2'd0,
        SP_PUSH = 2'd1,
        SP_POP  = 2'd2,
        SP_CLR  = 2'd3
    } sp_op_e;

    function automatic opc_t opcode_of(input word_t w);
        return w[OPC_LSB +: OPC_W];
    endfunction

    function automatic logic odd_ones(input word_t w);
        return ^w;
    endfunction

    function automatic logic rsv_nonzero(input word_t w);
        return |w[RSV_LSB +: RSV_W];
    endfunction

    function automatic logic misaligned(input word_t w);
        return |w[ALIGN_W-1:0];
    endfunction

    function automatic logic any_err(input instr_err_t e);
        return e.parity_bad | e.opc_bad | e.rsv_bad;
    endfunction

endpackage

// File: rtl/bcw_word_decode.sv
module bcw_word_decode
    import bcw_pkg::*;
#(
    parameter logic [63:0] LEGAL_OPC_MASK = 64'h0000_0000_0000_FFFF
) (
    input  word_t      word_i,
    output instr_err_t err_o,
    output opc_t       opc_o,
    output logic       ptr_bad_o
);

    logic [OPC_N-1:0] legal_vec;

    genvar g;
    generate
        for (g = 0; g < OPC_N; g++) begin : g_legal
            assign legal_vec[g] = LEGAL_OPC_MASK[g];
        end
    endgenerate

    always_comb begin
        opc_o            = opcode_of(word_i);
        err_o.parity_bad = !odd_ones(word_i);
        err_o.opc_bad    = !legal_vec[opc_o];
        err_o.rsv_bad    = rsv_nonzero(word_i);
        ptr_bad_o        = misaligned(word_i);
    end

endmodule

// File: rtl/bcw_call_stack.sv
module bcw_call_stack
    import bcw_pkg::*;
#(
    parameter int STACK_DEPTH = 8,
    localparam int SP_W = $clog2(STACK_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  sp_op_e          op_i,
    output logic [SP_W-1:0] sp_o
);

    localparam logic [SP_W-1:0] SP_MAX = SP_W'(STACK_DEPTH);

    logic [SP_W-1:0] sp_q, sp_d;

    always_comb begin
        sp_d = sp_q;
        unique case (op_i)
            SP_CLR:  sp_d = '0;
            SP_PUSH: if (sp_q != SP_MAX) sp_d = sp_q + 1'b1;
            SP_POP:  if (sp_q != '0)     sp_d = sp_q - 1'b1;
            default: sp_d = sp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sp_q <= '0;
        else     sp_q <= sp_d;
    end

    assign sp_o = sp_q;

endmodule

// File: rtl/bcw_trap_ctrl.sv
module bcw_trap_ctrl
    import bcw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       take_instr_i,
    input  instr_err_t instr_err_i,
    input  logic       take_ptr_i,
    input  logic       ptr_bad_i,
    input  logic       irq_en_i,
    output logic       halt_o,
    output logic       par_irq_o,
    output logic       align_irq_o
);

    logic instr_trap, ptr_trap;
    logic halt_q, par_q, aln_q;

    always_comb begin
        instr_trap = take_instr_i & any_err(instr_err_i);
        ptr_trap   = take_ptr_i & ptr_bad_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b1;
            par_q  <= 1'b0;
            aln_q  <= 1'b0;
        end else begin
            if (start_i)                     halt_q <= 1'b0;
            else if (instr_trap || ptr_trap) halt_q <= 1'b1;
            par_q <= instr_trap & irq_en_i;
            aln_q <= ptr_trap & irq_en_i;
        end
    end

    assign halt_o      = halt_q;
    assign par_irq_o   = par_q;
    assign align_irq_o = aln_q;

endmodule

// File: rtl/bcw_word_guard.sv
module bcw_word_guard
    import bcw_pkg::*;
#(
    parameter int          STACK_DEPTH    = 8,
    parameter logic [63:0] LEGAL_OPC_MASK = 64'h0000_0000_0000_FFFF,
    parameter logic [5:0]  OPC_CALL       = 6'h04,
    parameter logic [5:0]  OPC_RET        = 6'h05,
    localparam int SP_W = $clog2(STACK_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            word_valid_i,
    input  logic [15:0]     word_i,
    input  logic            param_i,
    input  logic            irq_en_i,
    output logic            halt_o,
    output logic            par_irq_o,
    output logic            align_irq_o,
    output logic [SP_W-1:0] sp_o
);

    instr_err_t err;
    opc_t       opc;
    logic       ptr_bad;
    logic       take, take_instr, take_ptr, clean_instr;
    sp_op_e     sp_op;

    bcw_word_decode #(
        .LEGAL_OPC_MASK(LEGAL_OPC_MASK)
    ) u_decode (
        .word_i   (word_i),
        .err_o    (err),
        .opc_o    (opc),
        .ptr_bad_o(ptr_bad)
    );

    always_comb begin
        take        = word_valid_i & ~halt_o & ~start_i;
        take_instr  = take & ~param_i;
        take_ptr    = take & param_i;
        clean_instr = take_instr & ~any_err(err);
        if (start_i)                             sp_op = SP_CLR;
        else if (clean_instr && opc == OPC_CALL) sp_op = SP_PUSH;
        else if (clean_instr && opc == OPC_RET)  sp_op = SP_POP;
        else                                     sp_op = SP_HOLD;
    end

    bcw_call_stack #(
        .STACK_DEPTH(STACK_DEPTH)
    ) u_stack (
        .clk (clk),
        .rst (rst),
        .op_i(sp_op),
        .sp_o(sp_o)
    );

    bcw_trap_ctrl u_trap (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .take_instr_i(take_instr),
        .instr_err_i (err),
        .take_ptr_i  (take_ptr),
        .ptr_bad_i   (ptr_bad),
        .irq_en_i    (irq_en_i),
        .halt_o      (halt_o),
        .par_irq_o   (par_irq_o),
        .align_irq_o (align_irq_o)
    );

endmodule

// File: rtl/bcw_word_guard_chk.sv
module bcw_word_guard_chk #(
    parameter int STACK_DEPTH = 8,
    localparam int SP_W = $clog2(STACK_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic            word_valid_i,
    input logic [15:0]     word_i,
    input logic            param_i,
    input logic            irq_en_i,
    input logic            halt_o,
    input logic            par_irq_o,
    input logic            align_irq_o,
    input logic [SP_W-1:0] sp_o
);

    logic live_instr, live_ptr;
    assign live_instr = word_valid_i && !param_i && !halt_o && !start_i;
    assign live_ptr   = word_valid_i && param_i && !halt_o && !start_i;

    AST_EVEN_ONES_TRAPS: assert property (@(posedge clk) disable iff (rst)
        live_instr && ($countones(word_i) % 2 == 0) |=> halt_o); // R1

    AST_RSV_FIELD_TRAPS: assert property (@(posedge clk) disable iff (rst)
        live_instr && (word_i[9:5] != 5'b0) |=> halt_o); // R3

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halt_o && !start_i |=> halt_o); // R4

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        par_irq_o |=> !par_irq_o); // R5

    AST_IRQ_WITH_HALT: assert property (@(posedge clk) disable iff (rst)
        par_irq_o |-> halt_o); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !irq_en_i |=> !par_irq_o && !align_irq_o); // R5

    AST_PTR_ALIGN_TRAPS: assert property (@(posedge clk) disable iff (rst)
        live_ptr && (word_i[2:0] != 3'b0) |=> halt_o); // R6

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !halt_o && (sp_o == '0) && !par_irq_o && !align_irq_o); // R7

    AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (rst)
        halt_o && !start_i |=> $stable(sp_o) && !par_irq_o && !align_irq_o); // R9

    AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (sp_o == $past(sp_o)) || (sp_o == $past(sp_o) + 1'b1)
                     || (sp_o == $past(sp_o) - 1'b1)); // R10

    AST_SP_BOUND: assert property (@(posedge clk) disable iff (rst)
        sp_o <= SP_W'(STACK_DEPTH)); // R10

endmodule

bind bcw_word_guard bcw_word_guard_chk #(
    .STACK_DEPTH(STACK_DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .word_valid_i(word_valid_i),
    .word_i      (word_i),
    .param_i     (param_i),
    .irq_en_i    (irq_en_i),
    .halt_o      (halt_o),
    .par_irq_o   (par_irq_o),
    .align_irq_o (align_irq_o),
    .sp_o        (sp_o)
);

// File: tb/test_bcw_word_guard.sv
module test_bcw_word_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [15:0] word_i = '0;
    logic        param_i = 1'b0;
    logic        irq_en_i = 1'b1;
    logic        halt_o, par_irq_o, align_irq_o;
    logic [3:0]  sp_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    bcw_word_guard i_bcw_word_guard (
        .clk(clk), .rst(rst), .start_i(start_i), .word_valid_i(word_valid_i),
        .word_i(word_i), .param_i(param_i), .irq_en_i(irq_en_i),
        .halt_o(halt_o), .par_irq_o(par_irq_o), .align_irq_o(align_irq_o),
        .sp_o(sp_o)
    );

    // {word, param, exp halt, exp par irq, exp align irq}
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {16'h0400, 4'b0000},  // R11 good, opcode 1
        {16'h0401, 4'b0110},  // R1 even ones
        {16'h3C01, 4'b0000},  // R2 opcode 15 legal
        {16'h4000, 4'b0110},  // R2 opcode 16 illegal
        {16'h0421, 4'b0110},  // R3 bit 5 set
        {16'h0601, 4'b0110},  // R3 bit 9 set
        {16'h041E, 4'b0000},  // R11 good with low bits used
        {16'h0108, 4'b1000},  // R6 aligned, even ones ignored
        {16'h0109, 4'b1101},  // R6 bit 0 misaligned
        {16'h010C, 4'b1101},  // R6 bit 2 misaligned
        {16'hFFF8, 4'b1000},  // R6 aligned
        {16'h0001, 4'b0000}   // R11 good, opcode 0
    };

    function automatic string vec_tag(input int i);
        case (i)
            1:       return "R1";
            2, 3:    return "R2";
            4, 5:    return "R3";
            7, 8, 9, 10: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic v, input logic p, input logic [15:0] w);
        @(negedge clk);
        start_i = s; word_valid_i = v; param_i = p; word_i = w;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R8 reset state
        check("R8", "halt", int'(halt_o), 1);
        check("R8", "sp", int'(sp_o), 0);
        check("R8", "irqs", int'(par_irq_o | align_irq_o), 0);

        for (int i = 0; i < NV; i++) begin
            step(1'b1, 1'b0, 1'b0, 16'h0);
            step(1'b0, 1'b1, VEC[i][3], VEC[i][19:4]);
            check(vec_tag(i), "halt", int'(halt_o), int'(VEC[i][2]));
            check(vec_tag(i), "par_irq", int'(par_irq_o), int'(VEC[i][1]));
            check(vec_tag(i), "align_irq", int'(align_irq_o), int'(VEC[i][0]));
        end

        // R4 sticky halt, R9 halted words ignored
        step(1'b0, 1'b1, 1'b0, 16'h0401);
        check("R4", "halt after error", int'(halt_o), 1);
        step(1'b0, 1'b1, 1'b0, 16'h0400);
        check("R4", "halt held", int'(halt_o), 1);
        check("R9", "no irq while halted", int'(par_irq_o), 0);
        step(1'b0, 1'b1, 1'b0, 16'h1000);
        check("R9", "sp unchanged while halted", int'(sp_o), 0);
        step(1'b0, 1'b1, 1'b1, 16'h0003);
        check("R9", "no align irq while halted", int'(align_irq_o), 0);

        // R7 start with a bad word in the same cycle
        step(1'b1, 1'b1, 1'b0, 16'h0401);
        check("R7", "halt cleared", int'(halt_o), 0);
        check("R7", "word ignored", int'(par_irq_o), 0);

        // R5 interrupt disabled and pulse width
        irq_en_i = 1'b0;
        step(1'b0, 1'b1, 1'b0, 16'h0401);
        check("R5", "halt with irq off", int'(halt_o), 1);
        check("R5", "no irq when off", int'(par_irq_o), 0);
        irq_en_i = 1'b1;
        step(1'b1, 1'b0, 1'b0, 16'h0);
        step(1'b0, 1'b1, 1'b0, 16'h4000);
        check("R5", "irq pulse", int'(par_irq_o), 1);
        step(1'b0, 1'b0, 1'b0, 16'h0);
        check("R5", "irq one cycle", int'(par_irq_o), 0);

        // R10 call stack
        step(1'b1, 1'b0, 1'b0, 16'h0);
        step(1'b0, 1'b1, 1'b0, 16'h1401);
        check("R10", "return at zero", int'(sp_o), 0);
        step(1'b0, 1'b1, 1'b1, 16'h1000);
        check("R10", "param not a call", int'(sp_o), 0);
        step(1'b0, 1'b1, 1'b0, 16'h1000);
        check("R10", "first call", int'(sp_o), 1);
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 1'b0, 16'h1000);
        check("R10", "saturate", int'(sp_o), 8);
        step(1'b0, 1'b1, 1'b0, 16'h1401);
        check("R10", "return", int'(sp_o), 7);
        step(1'b0, 1'b1, 1'b0, 16'h1001);
        check("R10", "bad call no push", int'(sp_o), 7);
        check("R1", "bad call halts", int'(halt_o), 1);
        step(1'b1, 1'b0, 1'b0, 16'h0);
        check("R7", "start clears sp", int'(sp_o), 0);
        check("R7", "start clears halt", int'(halt_o), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule